// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This block sits on the controller side of a four-bank SDRAM with a 16-bit data bus. A write request arrives for a row that is already open. It carries a bank, a start column, a burst-length code, an auto-precharge flag and a CAS-latency select. The sequencer then drives the command pins, the bank and address lines, the DQ output enable and the DQM mask cycle by cycle. It ends the burst in one of three ways: with an explicit precharge after the write-recovery gap, with a write that carries auto-precharge, or with a read that cuts the write short.

The write-recovery count and the precharge count are computed at elaboration time from picosecond parameters. Each is rounded up to whole clocks and is never less than one. While any of these windows is running, and while data from an interrupting read is still due, `busy` stays high and the sequencer drives only NOP. Row activation is left to the caller, who may issue an activate once `busy` has fallen.

Top module: `sdram_wr_term`

## Requirements
- R1: A request taken while idle produces, in the next cycle, a write command with RAS#=1, CAS#=0 and WE#=0. BA carries the bank and A[7:0] the column. A10 carries the auto-precharge flag, except that A10 is forced low when the burst-length code is 3.
- R2: The write-recovery count NWR is ceil(TWR_PS/TCK_PS) and the precharge count NRP is ceil(TRP_PS/TCK_PS). Each is at least 1.
- R3: In a write without auto-precharge, the write command is in cycle 0 and L is the burst length. The precharge (RAS#=0, CAS#=1, WE#=0, A10 low, same BA) appears in cycle L+NWR-1, which is NWR edges after the edge that registers the last data word.
- R4: In that case, for L of 4 or more, DQM is high in every cycle from L through the precharge cycle. For L of 1 or 2, DQM stays low throughout.
- R5: An uninterrupted burst drives dq_oe high for exactly cycles 0 to L-1. The burst-length codes are 0→1, 1→2, 2→4 and 3→full page (PAGE_LEN words).
- R6: A write with auto-precharge issues no further command and keeps busy high through cycle L+NWR+NRP-2. busy is low in cycle L-1+NWR+NRP.
- R7: A full-page write that requests auto-precharge behaves as a plain write. It issues no precharge and is idle in cycle L.
- R8: rd_req may be sampled at an edge where write words remain (edges 1 to L-1) in a write without active auto-precharge. A read command is then issued in the next cycle j, with RAS#=1, CAS#=0, WE#=1, A10 low and the column taken from rd_col. dq_oe is low from cycle j on, and neither a further write word nor a precharge follows.
- R9: After an interrupting read in cycle j, rd_valid is high for cycles j+CL to j+CL+L-1 and busy falls in cycle j+CL+L. CL is 2 when req_cl3=0 and 3 when req_cl3=1, sampled with the request.
- R10: After a precharge in cycle P, busy stays high through cycle P+NRP-1 and is low in cycle P+NRP.
- R11: Every cycle without a scheduled command drives NOP (all three strobes high). req_valid is ignored while busy. rd_req is ignored in auto-precharge writes and at the edge after the last word.
- R12: During and after reset the outputs are NOP, and busy, dq_oe, dqm and rd_valid are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request, taken when idle |
| req_bank | input | 2 | Target bank |
| req_col | input | 8 | Start column |
| req_bl | input | 2 | Burst-length code |
| req_ap | input | 1 | Auto-precharge requested |
| req_cl3 | input | 1 | CAS latency select (0: 2, 1: 3) |
| rd_req | input | 1 | Interrupting read request |
| rd_col | input | 8 | Column of the interrupting read |
| busy | output | 1 | Sequence or timing window in progress |
| sd_ras_n | output | 1 | RAS# strobe |
| sd_cas_n | output | 1 | CAS# strobe |
| sd_we_n | output | 1 | WE# strobe |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 11 | Address lines A10..A0 |
| dq_oe | output | 1 | Drive write data onto DQ |
| dqm | output | 1 | Data mask |
| rd_valid | output | 1 | Read data on DQ this cycle |

## Verification
The bench builds the block with a 20000 ps clock, TWR_PS=30000 and TRP_PS=45000, so NWR=2 and NRP=3. With these values a real write-recovery gap exists before the precharge, and the DQM window covers more than the precharge cycle alone. PAGE_LEN is set to 8, so full-page bursts and reads interrupting them at their first and last legal edge finish in a few dozen cycles. Both CAS latencies are exercised, which separates the two rd_valid windows.

// File: rtl/sdram_wr_term.sv
module sdram_wr_term #(
  parameter int TCK_PS   = 10000,
  parameter int TWR_PS   = 15000,
  parameter int TRP_PS   = 20000,
  parameter int PAGE_LEN = 256,
  parameter int COL_W    = 8,
  parameter int BA_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [COL_W-1:0] req_col,
  input  logic [1:0]       req_bl,
  input  logic             req_ap,
  input  logic             req_cl3,
  input  logic             rd_req,
  input  logic [COL_W-1:0] rd_col,
  output logic             busy,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [10:0]      sd_addr,
  output logic             dq_oe,
  output logic             dqm,
  output logic             rd_valid
);
  localparam int NWR_C = (TWR_PS + TCK_PS - 1) / TCK_PS;
  localparam int NRP_C = (TRP_PS + TCK_PS - 1) / TCK_PS;
  localparam int NWR   = (NWR_C < 1) ? 1 : NWR_C;
  localparam int NRP   = (NRP_C < 1) ? 1 : NRP_C;
  localparam int CW    = $clog2(PAGE_LEN + NWR + NRP + 8);

  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_PRE = 3'b010;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_REC, S_WAIT, S_RD} st_t;

  st_t           st;
  logic [CW-1:0] cnt, len;
  logic          ap_l, plain_l, mask_l, cl3_l;
  logic [2:0]    cmd;

  function automatic logic [CW-1:0] bl_len(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(1);
      2'd1:    return CW'(2);
      2'd2:    return CW'(4);
      default: return CW'(PAGE_LEN);
    endcase
  endfunction

  assign busy = (st != S_IDLE);
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; len <= '0;
      ap_l <= 1'b0; plain_l <= 1'b0; mask_l <= 1'b0; cl3_l <= 1'b0;
      cmd <= C_NOP; sd_ba <= '0; sd_addr <= '0;
      dq_oe <= 1'b0; dqm <= 1'b0; rd_valid <= 1'b0;
    end else begin
      cmd <= C_NOP; sd_addr <= '0;
      dq_oe <= 1'b0; dqm <= 1'b0; rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          cmd <= C_WR;
          sd_ba <= req_bank;
          sd_addr[COL_W-1:0] <= req_col;
          sd_addr[10] <= req_ap && (req_bl != 2'd3);
          ap_l <= req_ap && (req_bl != 2'd3);
          plain_l <= req_ap && (req_bl == 2'd3);
          mask_l <= (req_bl >= 2'd2);
          cl3_l <= req_cl3;
          len <= bl_len(req_bl);
          cnt <= bl_len(req_bl) - CW'(1);
          dq_oe <= 1'b1;
          st <= S_WR;
        end
        S_WR: if (cnt != '0) begin
          if (rd_req && !ap_l) begin
            cmd <= C_RD;
            sd_addr[COL_W-1:0] <= rd_col;
            cnt <= len + (cl3_l ? CW'(3) : CW'(2));
            st <= S_RD;
          end else begin
            dq_oe <= 1'b1;
            cnt <= cnt - CW'(1);
          end
        end else if (ap_l) begin
          cnt <= CW'(NWR + NRP - 1);
          st <= S_WAIT;
        end else if (plain_l) begin
          st <= S_IDLE;
        end else if (NWR == 1) begin
          cmd <= C_PRE; dqm <= mask_l;
          cnt <= CW'(NRP);
          st <= S_WAIT;
        end else begin
          dqm <= mask_l;
          cnt <= CW'(NWR - 1);
          st <= S_REC;
        end
        S_REC: begin
          dqm <= mask_l;
          if (cnt == CW'(1)) begin
            cmd <= C_PRE;
            cnt <= CW'(NRP);
            st <= S_WAIT;
          end else cnt <= cnt - CW'(1);
        end
        S_WAIT: if (cnt == CW'(1)) st <= S_IDLE; else cnt <= cnt - CW'(1);
        S_RD: if (cnt == CW'(1)) st <= S_IDLE;
        else begin
          cnt <= cnt - CW'(1);
          rd_valid <= (cnt - CW'(1)) <= len;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_write_drives_dq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_WR) |-> dq_oe);
  assert_read_releases_dq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD) |-> (!dq_oe && !sd_addr[10]));
  assert_bus_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!dq_oe));
  assert_pre_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE && mask_l) |-> dqm);
  assert_pre_single_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_PRE) |-> !sd_addr[10]);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dq_oe && !dqm && !rd_valid && cmd == C_NOP));
  assert_no_cmd_in_ap_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && ap_l) |-> (cmd == C_NOP));
endmodule

// File: tb/test_sdram_wr_term.sv
module test_sdram_wr_term;
  localparam int TCK = 20000, TWR = 30000, TRP = 45000, PL = 8;
  localparam int EWR = (TWR + TCK - 1) / TCK;
  localparam int ERP = (TRP + TCK - 1) / TCK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ap = 1'b0, req_cl3 = 1'b0, rd_req = 1'b0;
  logic [1:0] req_bank = '0, req_bl = '0;
  logic [7:0] req_col = '0, rd_col = '0;
  logic busy, ras_n, cas_n, we_n, dq_oe, dqm, rd_valid;
  logic [1:0] ba;
  logic [10:0] addr;
  int total = 0, bad = 0;
  int m_len, m_mode, m_j, m_cl, m_end;
  logic m_mask;

  always #10ns clk = ~clk;

  sdram_wr_term #(.TCK_PS(TCK), .TWR_PS(TWR), .TRP_PS(TRP), .PAGE_LEN(PL)) i_sdram_wr_term (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank), .req_col(req_col),
    .req_bl(req_bl), .req_ap(req_ap), .req_cl3(req_cl3), .rd_req(rd_req), .rd_col(rd_col),
    .busy(busy), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba),
    .sd_addr(addr), .dq_oe(dq_oe), .dqm(dqm), .rd_valid(rd_valid));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int blen(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 4 : PL;
  endfunction

  // {ras,cas,we,oe,dqm,rdv,busy} expected in cycle k
  function automatic logic [6:0] expv(input int k);
    logic [2:0] c;
    logic oe, mk, rv;
    int p;
    c = 3'b111; oe = 0; mk = 0; rv = 0;
    p = m_len + EWR - 1;
    if (k == 0) c = 3'b100;
    case (m_mode)
      0: begin
        oe = k < m_len;
        if (k == p) c = 3'b010;
        mk = m_mask && k >= m_len && k <= p;
      end
      3: begin
        oe = k < m_j;
        if (k == m_j) c = 3'b101;
        rv = k >= m_j + m_cl && k < m_j + m_cl + m_len;
      end
      default: oe = k < m_len;
    endcase
    return {c, oe, mk, rv, k < m_end};
  endfunction

  task automatic run(input logic [1:0] bank, input logic [7:0] col, input logic [1:0] bl,
                     input logic ap, input logic cl3, input int j, input logic [7:0] rcol,
                     input bit poke);
    string tag;
    m_len = blen(bl);
    m_cl = cl3 ? 3 : 2;
    m_mask = m_len > 2;
    m_j = j;
    if (ap && bl != 3) m_mode = 1;
    else if (j != 0) m_mode = 3;
    else if (ap) m_mode = 2;
    else m_mode = 0;
    case (m_mode)
      0: begin m_end = m_len + EWR - 1 + ERP; tag = "R3 R4 R5 R10 (R2 counts)"; end
      1: begin m_end = m_len - 1 + EWR + ERP; tag = "R6 R11"; end
      2: begin m_end = m_len; tag = "R7"; end
      default: begin m_end = j + m_cl + m_len; tag = "R8 R9"; end
    endcase
    @(negedge clk);
    req_bank = bank; req_col = col; req_bl = bl; req_ap = ap; req_cl3 = cl3;
    rd_col = rcol; req_valid = 1'b1;
    for (int k = 0; k <= m_end; k++) begin
      @(negedge clk);
      check({ras_n, cas_n, we_n, dq_oe, dqm, rd_valid, busy} == expv(k), tag,
            {ras_n, cas_n, we_n, dq_oe, dqm, rd_valid, busy}, expv(k));
      if (k == 0)
        check(ba == bank && addr == {(ap && bl != 3), 2'b00, col}, "R1",
              {ba, addr}, {bank, (ap && bl != 3), 2'b00, col});
      if (m_mode == 0 && k == m_len + EWR - 1)
        check(ba == bank && !addr[10], "R3", {ba, addr[10]}, {bank, 1'b0});
      if (m_mode == 3 && k == j)
        check(addr == {3'b000, rcol} && ba == bank, "R8", addr, {3'b000, rcol});
      req_valid = poke && (k + 1 <= m_end - 1);
      req_bl = poke ? ~bl : bl;
      rd_req = (j != 0) && (k == j - 1);
    end
    req_valid = 1'b0; rd_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] rbl;
    int rj;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check({ras_n, cas_n, we_n, dq_oe, dqm, rd_valid, busy} == 7'b1110000, "R12",
          {ras_n, cas_n, we_n, dq_oe, dqm, rd_valid, busy}, 7'b1110000);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && {ras_n, cas_n, we_n} == 3'b111, "R12", {busy, ras_n, cas_n, we_n}, 4'b0111);
    for (int b = 0; b < 4; b++) begin
      run(2'(b), 8'(8'h10 + b), 2'(b), 1'b0, 1'b0, 0, 8'h0, 1'b0);
      run(2'(3 - b), 8'(8'hA0 + b), 2'(b), 1'b0, 1'b1, 0, 8'h0, 1'b1);
    end
    for (int b = 0; b < 3; b++) run(2'(b), 8'h55, 2'(b), 1'b1, 1'b0, (b == 2) ? 2 : 0, 8'h0, 1'b1);
    run(2'd1, 8'h3C, 2'd3, 1'b1, 1'b0, 0, 8'h0, 1'b0);
    run(2'd2, 8'h00, 2'd2, 1'b0, 1'b0, 1, 8'h77, 1'b0);
    run(2'd2, 8'h04, 2'd2, 1'b0, 1'b1, 3, 8'h78, 1'b0);
    run(2'd3, 8'hF8, 2'd3, 1'b0, 1'b0, 7, 8'h19, 1'b1);
    run(2'd0, 8'hF0, 2'd3, 1'b1, 1'b1, 1, 8'h2A, 1'b0);
    run(2'd0, 8'h33, 2'd1, 1'b0, 1'b1, 1, 8'h44, 1'b0);
    for (int n = 0; n < 40; n++) begin
      rbl = 2'($urandom % 4);
      rj = (blen(rbl) > 1 && ($urandom % 2)) ? 1 + int'($urandom % (blen(rbl) - 1)) : 0;
      run(2'($urandom), 8'($urandom), rbl, 1'($urandom), 1'($urandom), rj,
          8'($urandom), 1'($urandom));
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule